// File: doc/BRIEF.md
# Port-Switched Shadow ROM Decoder

This block decides whether an on-board ROM answers a bus memory cycle. It compares the 24-bit bus address against a configured window. The top byte of the address, A23 to A16, must equal a configured byte. The next five bits, A15 to A11, are each compared against a configured value, and each of them can be excluded from the compare by a don't-care bit. Excluding the low ones in turn gives 2K, 4K, 8K and larger windows.

The ROM can be hidden or exposed by software. A one-bit visibility flag starts in a configured power-up state. An I/O write to one configured 8-bit port moves the flag to the opposite of that state. The data byte of the write plays no part. When a memory read hits the window while the ROM is visible, the block asserts the ROM chip-select. It also pulls the bus PHANTOM line low, so that RAM at the same address stays off the bus. A status light shows whether the ROM is visible.

Top module: `romdec_top`

## Requirements
- R1: A hit requires address bits 23..16 to equal `cfg_hi_base` exactly. Any mismatch in that byte gives no chip-select.
- R2: Address bits 15..11 are compared bit by bit with `cfg_lo_base` (bit i of the field against address bit 11+i). Where bit i of `cfg_lo_dc` is 1, that address bit is ignored. Address bits 10..0 never affect the decode.
- R3: An I/O write whose address bits 7..0 equal `cfg_port` sets visibility to the opposite of `cfg_boot_vis`. Address bits above 7 are ignored for this compare. A write to any other port changes nothing. A second matching write leaves the flag where it is and does not toggle it back.
- R4: The new visibility takes effect at the first rising clock edge at which `io_wr` is sampled low after having been sampled high. Before that edge, the outputs still show the old state.
- R5: `rom_cs` is asserted only while `mem_rd` is high. A window address with `mem_rd` low goes to RAM, with no chip-select and PHANTOM left high.
- R6: While the ROM is hidden, no address raises `rom_cs`.
- R7: `phantom_n` is low exactly when `rom_cs` is high.
- R8: `rom_lit` is high exactly while the ROM is visible.
- R9: While the synchronous active-high `rst` is sampled high, visibility takes the value of `cfg_boot_vis` (1 = visible).
- R10: `rom_cs` and `phantom_n` follow `addr`, `mem_rd` and the configuration in the same cycle, with no register in that path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 24 | Bus address; bits 7..0 carry the port number in I/O cycles |
| mem_rd | input | 1 | Memory-read cycle status |
| io_wr | input | 1 | I/O write strobe, active high |
| cfg_hi_base | input | 8 | Required value of address bits 23..16 |
| cfg_lo_base | input | 5 | Required value of address bits 15..11 |
| cfg_lo_dc | input | 5 | Per-bit don't-care for address bits 15..11 |
| cfg_port | input | 8 | Control port number |
| cfg_boot_vis | input | 1 | Visibility after reset (1 = visible) |
| rom_cs | output | 1 | ROM chip-select, active high |
| phantom_n | output | 1 | Bus PHANTOM, active low |
| rom_lit | output | 1 | Status light, high while the ROM is visible |

## Verification
The decode outputs respond in the same cycle as their inputs. The bench therefore drives each address vector away from the clock edge, waits one time unit and compares the outputs against a window match computed from the address arithmetic. The visibility flag moves one clock edge after the strobe falls. The bench samples the outputs once after the falling strobe but before that edge, to see the old state, and once at the following falling clock edge, to see the new state. Reset state is sampled one half-period after the first edge with reset released.

// File: rtl/romdec_pkg.sv
package romdec_pkg;

    localparam int ADDR_W = 24;
    localparam int HI_LSB = 16;
    localparam int HI_W   = ADDR_W - HI_LSB;
    localparam int LO_LSB = 11;
    localparam int LO_W   = HI_LSB - LO_LSB;
    localparam int PORT_W = 8;

    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
        logic [LO_W-1:0] dc;
    } win_cfg_t;

    typedef enum logic {
        BOOT_HIDDEN = 1'b0,
        BOOT_SHOWN  = 1'b1
    } boot_mode_t;

    typedef struct packed {
        logic cs;
        logic phantom_n;
        logic lit;
    } rom_out_t;

    function automatic logic bit_ok(input logic a, input logic want, input logic dc);
        return dc | (a == want);
    endfunction

endpackage

// File: rtl/romdec_match.sv
module romdec_match
    import romdec_pkg::*;
#(
    parameter int HW = HI_W,
    parameter int LW = LO_W
) (
    input  logic [HW+LW-1:0] a_upper,
    input  win_cfg_t         cfg,
    output logic             hit
);
    logic [LW-1:0] lo_ok;
    logic          hi_ok;

    generate
        for (genvar i = 0; i < LW; i++) begin : g_lo
            assign lo_ok[i] = bit_ok(a_upper[i], cfg.lo[i], cfg.dc[i]);
        end
    endgenerate

    assign hi_ok = (a_upper[HW+LW-1:LW] == cfg.hi);
    assign hit   = hi_ok & (&lo_ok);
endmodule

// File: rtl/romdec_vis.sv
module romdec_vis
    import romdec_pkg::*;
#(
    parameter int PW = PORT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] port_addr,
    input  logic          io_wr,
    input  logic [PW-1:0] cfg_port,
    input  boot_mode_t    boot,
    output logic          vis
);
    logic wr_q;
    logic port_hit_q;
    logic vis_q;
    logic strobe_end;

    assign strobe_end = wr_q & ~io_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q       <= 1'b0;
            port_hit_q <= 1'b0;
            vis_q      <= (boot == BOOT_SHOWN);
        end else begin
            wr_q <= io_wr;
            if (io_wr)
                port_hit_q <= (port_addr == cfg_port);
            if (strobe_end && port_hit_q)
                vis_q <= (boot != BOOT_SHOWN);
        end
    end

    assign vis = vis_q;

    assert_vis_cause_R3: assert property (@(posedge clk) disable iff (rst)
        (vis_q != $past(vis_q)) |-> $past(strobe_end && port_hit_q));

    assert_vis_target_R4: assert property (@(posedge clk) disable iff (rst)
        (strobe_end && port_hit_q && $stable(boot)) |=> (vis_q == (boot != BOOT_SHOWN)));
endmodule

// File: rtl/romdec_gate.sv
module romdec_gate
    import romdec_pkg::*;
(
    input  logic     hit,
    input  logic     vis,
    input  logic     mem_rd,
    output rom_out_t o
);
    always_comb begin
        o.cs        = hit & vis & mem_rd;
        o.phantom_n = ~(hit & vis & mem_rd);
        o.lit       = vis;
    end
endmodule

// File: rtl/romdec_top.sv
module romdec_top
    import romdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              mem_rd,
    input  logic              io_wr,
    input  logic [HI_W-1:0]   cfg_hi_base,
    input  logic [LO_W-1:0]   cfg_lo_base,
    input  logic [LO_W-1:0]   cfg_lo_dc,
    input  logic [PORT_W-1:0] cfg_port,
    input  logic              cfg_boot_vis,
    output logic              rom_cs,
    output logic              phantom_n,
    output logic              rom_lit
);
    win_cfg_t   wcfg;
    boot_mode_t boot;
    logic       hit;
    logic       vis;
    rom_out_t   outs;
    logic       unused_mid;

    assign wcfg = '{hi: cfg_hi_base, lo: cfg_lo_base, dc: cfg_lo_dc};
    assign boot = boot_mode_t'(cfg_boot_vis);
    assign unused_mid = ^addr[LO_LSB-1:PORT_W];

    romdec_match #(.HW(HI_W), .LW(LO_W)) i_match (
        .a_upper (addr[ADDR_W-1:LO_LSB]),
        .cfg     (wcfg),
        .hit     (hit)
    );

    romdec_vis #(.PW(PORT_W)) i_vis (
        .clk       (clk),
        .rst       (rst),
        .port_addr (addr[PORT_W-1:0]),
        .io_wr     (io_wr),
        .cfg_port  (cfg_port),
        .boot      (boot),
        .vis       (vis)
    );

    romdec_gate i_gate (
        .hit    (hit),
        .vis    (vis),
        .mem_rd (mem_rd),
        .o      (outs)
    );

    assign rom_cs    = outs.cs;
    assign phantom_n = outs.phantom_n;
    assign rom_lit   = outs.lit;

    assert_cs_read_R5: assert property (@(posedge clk) disable iff (rst)
        rom_cs |-> mem_rd);

    assert_cs_shown_R6: assert property (@(posedge clk) disable iff (rst)
        rom_cs |-> rom_lit);

    assert_phantom_R7: assert property (@(posedge clk) disable iff (rst)
        (!phantom_n) |-> (rom_cs && mem_rd));

    assert_cs_hi_R1: assert property (@(posedge clk) disable iff (rst)
        rom_cs |-> (addr[ADDR_W-1:HI_LSB] == cfg_hi_base));
endmodule

// File: tb/test_romdec_top.sv
module test_romdec_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [23:0] addr;
    logic        mem_rd;
    logic        io_wr;
    logic [7:0]  cfg_hi_base;
    logic [4:0]  cfg_lo_base;
    logic [4:0]  cfg_lo_dc;
    logic [7:0]  cfg_port;
    logic        cfg_boot_vis;
    logic        rom_cs;
    logic        phantom_n;
    logic        rom_lit;

    int vectors = 0;
    int fails   = 0;

    always #(CLK_P/2) clk = ~clk;

    romdec_top i_romdec_top (
        .clk(clk), .rst(rst), .addr(addr), .mem_rd(mem_rd), .io_wr(io_wr),
        .cfg_hi_base(cfg_hi_base), .cfg_lo_base(cfg_lo_base), .cfg_lo_dc(cfg_lo_dc),
        .cfg_port(cfg_port), .cfg_boot_vis(cfg_boot_vis),
        .rom_cs(rom_cs), .phantom_n(phantom_n), .rom_lit(rom_lit)
    );

    function automatic logic exp_hit(input logic [23:0] a);
        logic ok;
        ok = ((a / 65536) % 256) == int'(cfg_hi_base);
        for (int i = 0; i < 5; i++)
            if (!cfg_lo_dc[i] && (((a / (2048 << i)) % 2) != ((cfg_lo_base >> i) & 1)))
                ok = 1'b0;
        return ok;
    endfunction

    task automatic check_bit(input string tag, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b (addr %h rd %b)", tag, act, exp, addr, mem_rd);
        end
    endtask

    task automatic check_outs(input logic vis_exp);
        logic cs_e;
        cs_e = exp_hit(addr) & vis_exp & mem_rd;
        check_bit("R1 R2 R5 R6 R10 rom_cs", rom_cs, cs_e);
        check_bit("R7 phantom_n", phantom_n, ~cs_e);
        check_bit("R8 rom_lit", rom_lit, vis_exp);
    endtask

    task automatic io_write(input logic [23:0] a);
        @(negedge clk);
        mem_rd = 1'b0; addr = a; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic sweep(input logic vis_exp);
        logic [4:0] masks [4];
        logic [7:0] his [3];
        masks[0] = 5'b00000; masks[1] = 5'b00001; masks[2] = 5'b00011; masks[3] = 5'b11111;
        his[0] = cfg_hi_base; his[1] = cfg_hi_base ^ 8'h01; his[2] = cfg_hi_base ^ 8'h80;
        for (int m = 0; m < 4; m++) begin
            cfg_lo_dc = masks[m];
            for (int lo = 0; lo < 32; lo++)
                for (int h = 0; h < 3; h++)
                    for (int rd = 0; rd < 2; rd++) begin
                        addr   = {his[h], 5'(lo), 11'((lo * 37 + h * 501) % 2048)};
                        mem_rd = rd[0];
                        #1;
                        check_outs(vis_exp);
                    end
        end
        cfg_lo_dc = 5'b00000;
    endtask

    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; addr = '0; mem_rd = 1'b0; io_wr = 1'b0;
        cfg_hi_base = 8'h0E; cfg_lo_base = 5'b10110; cfg_lo_dc = 5'b0;
        cfg_port = 8'h1D; cfg_boot_vis = 1'b1;
        for (int b = 0; b < 2; b++) begin
            cfg_boot_vis = b[0];
            rst = 1'b1;
            repeat (2) @(negedge clk);
            rst = 1'b0;
            @(negedge clk);
            // R9: reset state follows the boot configuration
            check_bit("R9 reset lit", rom_lit, b[0]);
            sweep(b[0]);
            // R3: another port, even with a matching upper byte, has no effect
            io_write({16'h001D, 8'h1C});
            @(negedge clk);
            check_bit("R3 wrong port", rom_lit, b[0]);
            // R3/R4: matching port with nonzero upper address bits
            io_write({16'hBEEF, 8'h1D});
            #1;
            check_bit("R4 before edge", rom_lit, b[0]);
            @(negedge clk);
            check_bit("R4 after edge", rom_lit, ~b[0]);
            // R3: second write does not toggle back
            io_write({16'h0000, 8'h1D});
            @(negedge clk);
            check_bit("R3 no toggle", rom_lit, ~b[0]);
            sweep(~b[0]);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule